// File: doc/BRIEF.md
# OSD Host Write Port Controller

This block connects a host processor to the frame store of an on-screen-display generator. The host talks to it over an 8-bit multiplexed bus. An address-phase write picks one of eight internal registers, and a data-phase write loads the picked register. The host loads a 16-bit quad-pixel word (four 4-bit pixels), a line address and a horizontal quad-pixel address, then sets the write bit in the command register. The block turns that command into memory write requests on a request/grant port. The video refresh logic, which sits outside this block, shares that port and decides when a grant is given.

A channel mask register lets one command write the same word to the same location in several channels. Control bits can step the horizontal or the line address by itself after each completed command, which saves address writes when drawing runs. A ready line tells the host when a new command may be issued. After reset the block first writes zero to every location of every channel, and only then accepts host traffic.

Top module: `osd_host_wr_port`

## Requirements
- R1: An address-phase write (hb_cs, hb_wr, hb_addr_sel high) latches hb_ad[2:0] as the register index. A data-phase write (hb_cs, hb_wr high, hb_addr_sel low) loads that register. While hb_cs and hb_rd are high, hb_rd_data shows the selected register; otherwise it is 0. The register indices are: 0 data high byte, 1 data low byte, 2 horizontal address, 3 line address bits above bit 7, 4 line address low byte, 5 control (bit 0 horizontal step, bit 1 line step), 6 channel mask, 7 command (bit 0 write, reads as 0). Fields narrower than 8 bits read back zero-extended.
- R2: A request carries mem_addr = {channel, line, horizontal}. The channel sits in the top bits and the horizontal address in the low HQ_W bits. mem_wdata = {data high, data low}.
- R3: mem_req stays high, with mem_addr and mem_wdata stable, until a cycle in which mem_gnt is high. That cycle completes the request.
- R4: hb_rdy is high exactly when the block is idle. It goes low in the cycle after a command is accepted and returns high in the cycle after the last grant of that command. No request is made while hb_rdy is high.
- R5: A command issues one request for each set bit of the channel mask, in ascending channel order.
- R6: While hb_rdy is low, all host writes are ignored. This covers address-phase writes, register loads and commands.
- R7: If the horizontal step bit is set, the horizontal address increments by one after each completed command, wrapping from its maximum to 0.
- R8: If the line step bit is set, the line address increments by one after each completed command, wrapping from its maximum to 0.
- R9: After reset, hb_rdy is low and all registers read 0. The block requests every address of every channel with data 0, in increasing address order (horizontal fastest, then line, then channel). It then goes idle.
- R10: The data and address registers keep their values between commands, so a repeated command writes the same word to the same location.
- R11: A command whose write bit is 0, or that finds the channel mask empty, makes no request and leaves hb_rdy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hb_cs | input | 1 | Host chip select |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_addr_sel | input | 1 | High for an address phase, low for a data phase |
| hb_ad | input | 8 | Host address/data byte |
| hb_rd_data | output | 8 | Register read-back byte |
| hb_rdy | output | 1 | Ready (high) / busy (low) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | CH_W+LINE_W+HQ_W | Channel, line and horizontal address |
| mem_wdata | output | 16 | Quad-pixel write word |
| mem_gnt | input | 1 | Memory slot granted this cycle |

## Verification
The assertions assume that the host strobes are single-cycle levels that change only between clock edges, and that hb_wr and hb_rd are never high together. They also assume that mem_gnt means anything only while mem_req is high. The stimulus drives every strobe on the falling edge and never raises both strobes at once. It uses three grant patterns: grant always given, grant pseudo-random, and grant withheld. The withheld pattern holds a request open while the bench tries writes that should be ignored. Each data and address register is set only with values that fit its field width.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;

   // Register indices on the host bus. Numbering is fixed by the host software contract.
   typedef enum logic [2:0] {
      REG_DHI  = 3'd0,
      REG_DLO  = 3'd1,
      REG_HZ   = 3'd2,
      REG_LHI  = 3'd3,
      REG_LLO  = 3'd4,
      REG_CTL  = 3'd5,
      REG_MASK = 3'd6,
      REG_CMD  = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      ST_CLR   = 2'd0,
      ST_IDLE  = 2'd1,
      ST_ISSUE = 2'd2
   } seq_st_e;

   localparam int PIX_PER_WORD = 4;
   localparam int PIX_BITS     = 4;
   localparam int WORD_W       = PIX_PER_WORD * PIX_BITS;
   localparam int CTL_HSTEP    = 0;
   localparam int CTL_VSTEP    = 1;
   localparam int CMD_WRITE    = 0;

endpackage

// File: rtl/osd_low_pick.sv
module osd_low_pick #(
   parameter  int N  = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/osd_host_regs.sv
module osd_host_regs
   import osd_wr_pkg::*;
#(
   parameter int CH_N   = 8,
   parameter int LINE_W = 9,
   parameter int HQ_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              hb_cs,
   input  logic              hb_wr,
   input  logic              hb_addr_sel,
   input  logic [7:0]        hb_ad,
   input  logic              step_pulse,
   output logic [7:0]        reg_rd,
   output logic [WORD_W-1:0] data_word,
   output logic [LINE_W-1:0] line_addr,
   output logic [HQ_W-1:0]   horiz_addr,
   output logic [CH_N-1:0]   ch_mask,
   output logic              cmd_start
);

   localparam int LO_W = (LINE_W > 8) ? 8 : LINE_W;

   logic [2:0]        ptr_q;
   logic [7:0]        dhi_q, dlo_q;
   logic [HQ_W-1:0]   hz_q;
   logic [LINE_W-1:0] ln_q, ln_load;
   logic              hstep_q, vstep_q;
   logic [CH_N-1:0]   mask_q;
   logic              wr_addr, wr_data;
   logic [7:0]        lhi_rd;
   reg_idx_e          sel;

   assign wr_addr = hb_cs & hb_wr &  hb_addr_sel & acc_en;
   assign wr_data = hb_cs & hb_wr & ~hb_addr_sel & acc_en;
   assign sel     = reg_idx_e'(ptr_q);

   generate
      if (LINE_W > 8) begin : g_line_wide
         always_comb begin
            ln_load = ln_q;
            if (wr_data && sel == REG_LHI) ln_load[LINE_W-1:8] = hb_ad[LINE_W-9:0];
            if (wr_data && sel == REG_LLO) ln_load[7:0] = hb_ad;
         end
         assign lhi_rd = 8'(ln_q[LINE_W-1:8]);
      end else begin : g_line_narrow
         always_comb begin
            ln_load = ln_q;
            if (wr_data && sel == REG_LLO) ln_load = hb_ad[LINE_W-1:0];
         end
         assign lhi_rd = 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         dhi_q   <= '0;
         dlo_q   <= '0;
         hz_q    <= '0;
         ln_q    <= '0;
         hstep_q <= 1'b0;
         vstep_q <= 1'b0;
         mask_q  <= '0;
      end else begin
         if (wr_addr) ptr_q <= hb_ad[2:0];
         if (wr_data) begin
            case (sel)
               REG_DHI:  dhi_q <= hb_ad;
               REG_DLO:  dlo_q <= hb_ad;
               REG_HZ:   hz_q  <= hb_ad[HQ_W-1:0];
               REG_CTL: begin
                  hstep_q <= hb_ad[CTL_HSTEP];
                  vstep_q <= hb_ad[CTL_VSTEP];
               end
               REG_MASK: mask_q <= hb_ad[CH_N-1:0];
               default: ;
            endcase
         end
         if (step_pulse && hstep_q) hz_q <= hz_q + 1'b1;
         if (step_pulse && vstep_q) ln_q <= ln_q + 1'b1;
         else                       ln_q <= ln_load;
      end
   end

   always_comb begin
      case (sel)
         REG_DHI:  reg_rd = dhi_q;
         REG_DLO:  reg_rd = dlo_q;
         REG_HZ:   reg_rd = 8'(hz_q);
         REG_LHI:  reg_rd = lhi_rd;
         REG_LLO:  reg_rd = 8'(ln_q[LO_W-1:0]);
         REG_CTL:  reg_rd = {6'b0, vstep_q, hstep_q};
         REG_MASK: reg_rd = 8'(mask_q);
         default:  reg_rd = 8'h00;
      endcase
   end

   assign cmd_start  = wr_data && sel == REG_CMD && hb_ad[CMD_WRITE];
   assign data_word  = {dhi_q, dlo_q};
   assign line_addr  = ln_q;
   assign horiz_addr = hz_q;
   assign ch_mask    = mask_q;

endmodule

// File: rtl/osd_wr_seq.sv
module osd_wr_seq
   import osd_wr_pkg::*;
#(
   parameter  int CH_N   = 8,
   parameter  int LINE_W = 9,
   parameter  int HQ_W   = 8,
   localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1,
   localparam int AW     = CH_W + LINE_W + HQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [CH_N-1:0]   ch_mask,
   input  logic [LINE_W-1:0] line_addr,
   input  logic [HQ_W-1:0]   horiz_addr,
   input  logic [WORD_W-1:0] data_word,
   input  logic              mem_gnt,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              ready,
   output logic              step_pulse,
   output logic              clr_active
);

   seq_st_e           st_q;
   logic [CH_W-1:0]   clr_c;
   logic [LINE_W-1:0] clr_l;
   logic [HQ_W-1:0]   clr_h;
   logic [CH_N-1:0]   rem_q, pick_oh;
   logic [CH_W-1:0]   pick_idx;
   logic              gnt_hit, last;

   osd_low_pick #(.N(CH_N)) u_pick (.vec(rem_q), .idx(pick_idx));

   assign pick_oh    = CH_N'(1) << pick_idx;
   assign last       = (rem_q & ~pick_oh) == '0;
   assign clr_active = st_q == ST_CLR;
   assign ready      = st_q == ST_IDLE;
   assign mem_req    = st_q != ST_IDLE;
   assign gnt_hit    = mem_req & mem_gnt;
   assign step_pulse = st_q == ST_ISSUE && gnt_hit && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_CLR;
         clr_c <= '0;
         clr_l <= '0;
         clr_h <= '0;
         rem_q <= '0;
      end else begin
         case (st_q)
            ST_CLR: if (gnt_hit) begin
               clr_h <= clr_h + 1'b1;
               if (&clr_h) begin
                  clr_l <= clr_l + 1'b1;
                  if (&clr_l) begin
                     clr_c <= clr_c + 1'b1;
                     if (clr_c == CH_W'(CH_N - 1)) st_q <= ST_IDLE;
                  end
               end
            end
            ST_IDLE: if (cmd_start && |ch_mask) begin
               rem_q <= ch_mask;
               st_q  <= ST_ISSUE;
            end
            ST_ISSUE: if (gnt_hit) begin
               rem_q <= rem_q & ~pick_oh;
               if (last) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (clr_active) begin
         mem_addr  = {clr_c, clr_l, clr_h};
         mem_wdata = '0;
      end else begin
         mem_addr  = {pick_idx, line_addr, horiz_addr};
         mem_wdata = data_word;
      end
   end

endmodule

// File: rtl/osd_host_wr_port.sv
module osd_host_wr_port
   import osd_wr_pkg::*;
#(
   parameter  int CH_N   = 8,
   parameter  int LINE_W = 9,
   parameter  int HQ_W   = 8,
   localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1,
   localparam int AW     = CH_W + LINE_W + HQ_W,
   localparam int CFG_W  = WORD_W + LINE_W + HQ_W + CH_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hb_cs,
   input  logic              hb_wr,
   input  logic              hb_rd,
   input  logic              hb_addr_sel,
   input  logic [7:0]        hb_ad,
   output logic [7:0]        hb_rd_data,
   output logic              hb_rdy,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_gnt
);

   generate
      if (CH_N < 1 || CH_N > 8) begin : g_bad_ch
         $error("CH_N must lie in 1..8 to fit the mask byte");
      end
      if (LINE_W < 1 || LINE_W > 16) begin : g_bad_line
         $error("LINE_W must lie in 1..16 to fit two address bytes");
      end
      if (HQ_W < 1 || HQ_W > 8) begin : g_bad_hz
         $error("HQ_W must lie in 1..8 to fit one address byte");
      end
      if (WORD_W != 16) begin : g_bad_word
         $error("quad-pixel word must be two bytes");
      end
   endgenerate

   logic [7:0]        reg_rd;
   logic [WORD_W-1:0] data_word;
   logic [LINE_W-1:0] line_addr;
   logic [HQ_W-1:0]   horiz_addr;
   logic [CH_N-1:0]   ch_mask;
   logic              cmd_start, step_pulse, clr_active;
   logic [CFG_W-1:0]  cfg_view;

   osd_host_regs #(.CH_N(CH_N), .LINE_W(LINE_W), .HQ_W(HQ_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .acc_en(hb_rdy),
      .hb_cs(hb_cs), .hb_wr(hb_wr), .hb_addr_sel(hb_addr_sel), .hb_ad(hb_ad),
      .step_pulse(step_pulse), .reg_rd(reg_rd), .data_word(data_word),
      .line_addr(line_addr), .horiz_addr(horiz_addr), .ch_mask(ch_mask),
      .cmd_start(cmd_start)
   );

   osd_wr_seq #(.CH_N(CH_N), .LINE_W(LINE_W), .HQ_W(HQ_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .ch_mask(ch_mask),
      .line_addr(line_addr), .horiz_addr(horiz_addr), .data_word(data_word),
      .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .ready(hb_rdy), .step_pulse(step_pulse),
      .clr_active(clr_active)
   );

   assign hb_rd_data = (hb_cs && hb_rd) ? reg_rd : 8'h00;
   assign cfg_view   = {data_word, line_addr, horiz_addr, ch_mask};

endmodule

// File: rtl/osd_host_wr_port_chk.sv
module osd_host_wr_port_chk #(
   parameter int AW    = 20,
   parameter int CH_W  = 3,
   parameter int CFG_W = 41
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hb_cs,
   input logic             hb_wr,
   input logic             hb_rdy,
   input logic             mem_req,
   input logic             mem_gnt,
   input logic [AW-1:0]    mem_addr,
   input logic [15:0]      mem_wdata,
   input logic             clr_active,
   input logic [CFG_W-1:0] cfg_view
);

   // R3: an ungranted request holds its address and data
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

   // R4: ready and request never overlap
   p_rdy_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hb_rdy |-> !mem_req);

   // R5: within one command the channel field rises
   p_ch_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && !clr_active) |=>
         (!mem_req || (mem_addr[AW-1 -: CH_W] > $past(mem_addr[AW-1 -: CH_W]))));

   // R6: host writes while busy leave the loaded registers untouched
   p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hb_rdy && hb_cs && hb_wr && !(mem_req && mem_gnt)) |=> $stable(cfg_view));

   // R9: the clear walk writes zero and keeps the host waiting
   p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_active |-> (mem_wdata == 16'h0000 && !hb_rdy));

   // R9: the clear walk visits consecutive addresses
   p_clr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_active && mem_gnt) |=> (!clr_active || mem_addr == AW'($past(mem_addr) + 1'b1)));

endmodule

bind osd_host_wr_port osd_host_wr_port_chk #(.AW(AW), .CH_W(CH_W), .CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hb_cs(hb_cs), .hb_wr(hb_wr), .hb_rdy(hb_rdy),
   .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .clr_active(clr_active), .cfg_view(cfg_view)
);

// File: tb/osd_host_wr_port_bench.sv
`timescale 1ns/1ps
module osd_host_wr_port_bench;

   localparam int CH_N = 8, LINE_W = 2, HQ_W = 2;
   localparam int AW = 3 + LINE_W + HQ_W;
   localparam int NL = 1 << LINE_W, NH = 1 << HQ_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hb_cs = 0, hb_wr = 0, hb_rd = 0, hb_addr_sel = 0;
   logic [7:0] hb_ad = '0, hb_rd_data;
   logic hb_rdy, mem_req, mem_gnt = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [15:0] mem_wdata;

   int checks = 0, errors = 0, cyc = 0;
   int gnt_mode = 0;
   logic [31:0] lfsr = 32'h1234_5678;
   int log_a[$], log_d[$];

   // reference model state
   int m_st, m_cc, m_cl, m_ch, m_ptr, m_rem;
   int m_r[8];

   always #2 clk = ~clk;

   osd_host_wr_port #(.CH_N(CH_N), .LINE_W(LINE_W), .HQ_W(HQ_W)) u_osd_host_wr_port (
      .clk(clk), .rst_n(rst_n), .hb_cs(hb_cs), .hb_wr(hb_wr), .hb_rd(hb_rd),
      .hb_addr_sel(hb_addr_sel), .hb_ad(hb_ad), .hb_rd_data(hb_rd_data),
      .hb_rdy(hb_rdy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int lowest(input int v);
      for (int i = 0; i < CH_N; i++) if (v[i]) return i;
      return 0;
   endfunction

   function automatic int wmask(input int idx);
      case (idx)
         0, 1: return 255;
         2: return NH - 1;
         3: return 0;
         4: return NL - 1;
         5: return 3;
         6: return (1 << CH_N) - 1;
         default: return 0;
      endcase
   endfunction

   // grant source
   always @(negedge clk) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      case (gnt_mode)
         0: mem_gnt = 1'b1;
         1: mem_gnt = lfsr[16];
         default: mem_gnt = 1'b0;
      endcase
   end

   // reference model and per-cycle comparison
   always @(posedge clk) begin
      int line, ea, ed, er;
      cyc++;
      if (rst_n && mem_req && mem_gnt) begin
         log_a.push_back(int'(mem_addr));
         log_d.push_back(int'(mem_wdata));
      end
      if (!rst_n) begin
         m_st = 0; m_cc = 0; m_cl = 0; m_ch = 0; m_ptr = 0; m_rem = 0;
         for (int i = 0; i < 8; i++) m_r[i] = 0;
      end else begin
         case (m_st)
            0: if (mem_gnt) begin
               m_ch++;
               if (m_ch == NH) begin
                  m_ch = 0; m_cl++;
                  if (m_cl == NL) begin
                     m_cl = 0; m_cc++;
                     if (m_cc == CH_N) begin m_cc = 0; m_st = 1; end
                  end
               end
            end
            1: if (hb_cs && hb_wr) begin
               if (hb_addr_sel) m_ptr = int'(hb_ad) & 7;
               else if (m_ptr == 7) begin
                  if (hb_ad[0] && m_r[6] != 0) begin m_rem = m_r[6]; m_st = 2; end
               end else m_r[m_ptr] = int'(hb_ad) & wmask(m_ptr);
            end
            default: if (mem_gnt) begin
               m_rem = m_rem & ~(1 << lowest(m_rem));
               if (m_rem == 0) begin
                  m_st = 1;
                  if (m_r[5] & 1) m_r[2] = (m_r[2] + 1) % NH;
                  if (m_r[5] & 2) m_r[4] = (m_r[4] + 1) % NL;
               end
            end
         endcase
      end
      #1;
      line = (m_r[3] << 8) | m_r[4];
      chk(hb_rdy === (m_st == 1), "R4 rdy", int'(hb_rdy), int'(m_st == 1));
      chk(mem_req === (m_st != 1), "R3 req", int'(mem_req), int'(m_st != 1));
      if (m_st == 0) begin
         ea = (m_cc << (LINE_W + HQ_W)) | (m_cl << HQ_W) | m_ch;
         chk(int'(mem_addr) == ea, "R9 clear addr", int'(mem_addr), ea);
         chk(mem_wdata == 16'h0, "R9 clear data", int'(mem_wdata), 0);
      end else if (m_st == 2) begin
         ea = (lowest(m_rem) << (LINE_W + HQ_W)) | (line << HQ_W) | m_r[2];
         ed = (m_r[0] << 8) | m_r[1];
         chk(int'(mem_addr) == ea, "R2 addr", int'(mem_addr), ea);
         chk(int'(mem_wdata) == ed, "R2 data", int'(mem_wdata), ed);
      end
      er = (hb_cs && hb_rd) ? ((m_ptr == 7) ? 0 : m_r[m_ptr]) : 0;
      chk(int'(hb_rd_data) == er, "R1 readback", int'(hb_rd_data), er);
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL R4 watchdog: actual cycles=%0d expected<=20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic bus_wr(input bit asel, input int v);
      @(negedge clk);
      hb_cs = 1; hb_wr = 1; hb_addr_sel = asel; hb_ad = 8'(v);
      @(negedge clk);
      hb_cs = 0; hb_wr = 0; hb_addr_sel = 0; hb_ad = '0;
   endtask

   task automatic host_wr(input int idx, input int v);
      bus_wr(1'b1, idx);
      bus_wr(1'b0, v);
   endtask

   task automatic host_rd(input int idx, output int v);
      bus_wr(1'b1, idx);
      hb_cs = 1; hb_rd = 1;
      #1 v = int'(hb_rd_data);
      @(negedge clk);
      hb_cs = 0; hb_rd = 0;
   endtask

   task automatic wait_rdy();
      @(negedge clk);
      while (!hb_rdy) @(negedge clk);
   endtask

   task automatic run_cmd(input int v);
      log_a.delete(); log_d.delete();
      host_wr(7, v);
      wait_rdy();
   endtask

   initial begin
      int v;
      gnt_mode = 1;
      repeat (3) @(negedge clk);
      chk(hb_rdy == 1'b0, "R9 rdy low in reset", int'(hb_rdy), 0);
      rst_n = 1'b1;
      log_a.delete();
      wait_rdy();
      chk(log_a.size() == CH_N * NL * NH, "R9 clear count", log_a.size(), CH_N * NL * NH);
      host_rd(0, v);
      chk(v == 0, "R9 data reg after reset", v, 0);

      gnt_mode = 0;
      host_wr(0, 'hA5); host_wr(1, 'h3C); host_wr(2, 1); host_wr(4, 2);
      host_wr(5, 0); host_wr(6, 'h01);
      host_rd(0, v);
      chk(v == 'hA5, "R1 data high readback", v, 'hA5);
      run_cmd(1);
      chk(log_a.size() == 1 && log_a[0] == 'h09, "R2 single write addr", log_a.size() ? log_a[0] : -1, 'h09);
      chk(log_d.size() == 1 && log_d[0] == 'hA53C, "R2 single write data", log_d.size() ? log_d[0] : -1, 'hA53C);
      run_cmd(1);
      chk(log_a.size() == 1 && log_a[0] == 'h09 && log_d[0] == 'hA53C, "R10 repeat reuses regs",
          log_a.size() ? log_a[0] : -1, 'h09);

      gnt_mode = 1;
      host_wr(6, 'hA4);
      run_cmd(1);
      chk(log_a.size() == 3, "R5 multi-write count", log_a.size(), 3);
      if (log_a.size() == 3) begin
         chk((log_a[0] >> 4) == 2, "R5 first channel", log_a[0] >> 4, 2);
         chk((log_a[1] >> 4) == 5, "R5 second channel", log_a[1] >> 4, 5);
         chk((log_a[2] >> 4) == 7, "R5 third channel", log_a[2] >> 4, 7);
      end

      gnt_mode = 0;
      host_wr(6, 1); host_wr(5, 1); host_wr(2, 3);
      run_cmd(1);
      chk(log_a.size() == 1 && (log_a[0] & 3) == 3, "R7 horiz before step", log_a.size() ? log_a[0] & 3 : -1, 3);
      host_rd(2, v);
      chk(v == 0, "R7 horiz wraps to 0", v, 0);
      run_cmd(1);
      host_rd(2, v);
      chk(v == 1, "R7 horiz steps to 1", v, 1);

      host_wr(5, 2); host_wr(4, 3);
      run_cmd(1);
      chk(log_a.size() == 1 && ((log_a[0] >> 2) & 3) == 3, "R8 line before step",
          log_a.size() ? (log_a[0] >> 2) & 3 : -1, 3);
      host_rd(4, v);
      chk(v == 0, "R8 line wraps to 0", v, 0);
      host_rd(2, v);
      chk(v == 1, "R8 horiz unchanged without its step bit", v, 1);

      host_wr(5, 0);
      gnt_mode = 2;
      log_a.delete(); log_d.delete();
      host_wr(7, 1);
      chk(hb_rdy == 1'b0, "R4 busy while grant withheld", int'(hb_rdy), 0);
      host_wr(0, 'hFF);
      host_wr(7, 1);
      gnt_mode = 0;
      wait_rdy();
      repeat (3) @(negedge clk);
      chk(log_a.size() == 1, "R6 busy command dropped", log_a.size(), 1);
      host_rd(0, v);
      chk(v == 'hA5, "R6 busy write dropped", v, 'hA5);

      host_wr(6, 0);
      run_cmd(1);
      repeat (3) @(negedge clk);
      chk(log_a.size() == 0 && hb_rdy, "R11 empty mask ignored", log_a.size(), 0);
      host_wr(6, 1);
      run_cmd(0);
      repeat (3) @(negedge clk);
      chk(log_a.size() == 0 && hb_rdy, "R11 write bit clear ignored", log_a.size(), 0);

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule